// File: doc/BRIEF.md
# Triggered Frame Packetizer with Metadata Header

This block turns one continuous 32-bit sample stream into framed bursts on a streaming master interface (`tData`, `tValid`, `tLast`, `tUser`, with `tReady` back-pressure). Each accepted start pulse opens one frame. The frame length is given in 32-bit words. In triggered mode it can begin with a fixed 14-word metadata header. The header holds a snapshot, taken on the start cycle, of the timing pattern, the timestamp, four beam-synchronous words, the frame size and a packed descriptor word.

A frame opens only when these all hold at the start pulse: the stream is enabled, input data is valid, the consumer is ready and no pause is requested. In continuous mode a single start pulse begins framing. Frames then follow back to back until the stream enable is low at the end of a frame. Continuous frames carry no header, and a freeze request marks the last beat of the frame it falls in.

The block assumes the source and the consumer keep pace once a frame is running. If input valid or consumer ready drops in the middle of a frame, the frame is abandoned, an error flag is raised and output stops. A counter reports how many frames completed.

Top module: `trig_frame_packer`

## Requirements
- R1: Under reset, and after reset until a frame starts, `tValid` is 0, `errFlag` is 0 and `frameCount` is 0.
- R2: A frame starts, with its first beat presented in the next cycle, only when `startPulse`, `streamEn`, `sampleValid` and `tReady` are all 1 and `pauseIn` is 0 in the same cycle. Otherwise the pulse is ignored. While a frame runs, `tValid` equals `sampleValid`.
- R3: A frame carries exactly `frameLen` beats, and `tLast` is set on the beat with index `frameLen`-1. A `frameLen` below 14 is treated as 14.
- R4: With `hdrEn`=1 in triggered mode, beats 0..13 are header words. Words 0..5 are `timingWord` bits [32k+31:32k] for word k. Word 6 is `timeStamp`[31:0] and word 7 is `timeStamp`[63:32]. Words 8..11 are `beamSync`[127:96], [95:64], [63:32] and [31:0] in that order. Word 12 is the effective frame length. Data beats follow the header, and the header counts toward the frame length.
- R5: Header word 13 is {5'b0, `trigSrc`[2:0], `fmt16`, `avgEn`, `testMode`, `bayIdx`, `chanIdx`[3:0], `rateDiv`[15:0]}, from bit 31 down to bit 0. `trigSrc` bit 2 flags a hardware trigger, bit 1 a cascade trigger and bit 0 a software trigger.
- R6: Header words take the input values present on the start cycle. Later changes to those inputs do not alter the header of a running frame.
- R7: A data beat carries `sampleData` of the same cycle unchanged. Without a header, beat 0 is already a data beat.
- R8: In continuous mode (`contMode`=1 at the start), no header is produced whatever `hdrEn` is. After each last beat, a new frame begins in the next cycle if `streamEn` is 1 on that last beat. Otherwise framing stops.
- R9: In continuous mode, if `freezeReq` is 1 on any beat of a frame, `tUser` is 1 on that frame's last beat. `tUser` is 0 on every other beat and in triggered mode.
- R10: If `sampleValid` or `tReady` is 0 during a running frame, the frame is abandoned. `errFlag` is 1 from the next cycle and `tValid` stays 0. Start pulses are ignored until `streamEn` has been 0 for a cycle. `errFlag` clears when the next frame starts.
- R11: `frameCount` rises by one in the cycle after each accepted last beat. Abandoned frames are not counted.
- R12: A start pulse that arrives while a frame is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| startPulse | input | 1 | Start request |
| trigSrc | input | 3 | Trigger source flags: bit 2 hardware, bit 1 cascade, bit 0 software |
| streamEn | input | 1 | Stream enable |
| contMode | input | 1 | 1 selects continuous mode, 0 selects triggered mode |
| hdrEn | input | 1 | Header enable (triggered mode only) |
| pauseIn | input | 1 | Blocks a frame start while 1 |
| freezeReq | input | 1 | Freeze request, marks the last beat in continuous mode |
| frameLen | input | 16 | Frame length in 32-bit words, header included |
| sampleData | input | 32 | Sample word |
| sampleValid | input | 1 | Sample valid |
| timingWord | input | 192 | Timing pattern bits for header words 0..5 |
| timeStamp | input | 64 | Timestamp for header words 6..7 |
| beamSync | input | 128 | Beam-synchronous words for header words 8..11 |
| fmt16 | input | 1 | Sample format flag (16-bit when 1) |
| avgEn | input | 1 | Averaging enable flag |
| testMode | input | 1 | Test pattern flag |
| bayIdx | input | 1 | Bay index |
| chanIdx | input | 4 | Channel index |
| rateDiv | input | 16 | Rate divisor |
| tData | output | 32 | Output word |
| tValid | output | 1 | Output valid |
| tLast | output | 1 | Last beat of a frame |
| tUser | output | 1 | Freeze mark on the last beat |
| tReady | input | 1 | Consumer ready |
| errFlag | output | 1 | Last frame abandoned |
| frameCount | output | 16 | Completed frame counter |

## Verification
The bench compares every cycle with a behavioural model of the requirements. It drives directed cases mixed with seeded random traffic that toggles valid, ready, enable, mode and length.

- Lengths below the header size: a design without the clamp would stop frames short.
- Header field order and the packed descriptor word: a swapped or shifted field shows up as a wrong `tData` on that beat.
- Header inputs changed right after the start: a design without a snapshot would emit the new values.
- A start pulse in mid-frame: a design that honoured it would restart or lengthen the frame.
- Valid and ready drops: a design that failed to abort would keep streaming, count the frame, or clear the error flag too early.
- Continuous runs with a freeze pulse and a late disable: a wrong design would misplace `tUser` or stop after the wrong frame.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  localparam int WORD_W       = 32;
  localparam int TIMING_WORDS = 6;
  localparam int BSYNC_WORDS  = 4;
  localparam int HDR_N        = TIMING_WORDS + 2 + BSYNC_WORDS + 2;
  localparam int HDR_IDX_W    = $clog2(HDR_N);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // snapshot header fields, restart word index
    logic step;   // one beat accepted downstream
  } strobe_t;

  // descriptor word placed last in the header
  typedef struct packed {
    logic [4:0]  zero;
    logic [2:0]  trig;
    logic        fmt16;
    logic        avg;
    logic        test;
    logic        bay;
    logic [3:0]  chan;
    logic [15:0] rate;
  } descWord_t;
endpackage

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import pkt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startPulse,
  input  logic    streamEn,
  input  logic    contMode,
  input  logic    pauseIn,
  input  logic    freezeReq,
  input  logic    sampleValid,
  input  logic    tReady,
  input  logic    lastBeat,
  output strobe_t stb,
  output logic    tValid,
  output logic    tLast,
  output logic    tUser,
  output logic    errFlag
);
  ctrlState_t state, stateNxt;
  logic contLat;
  logic freezeSeen;
  logic startOk;
  logic beatOk;
  logic frameEnd;
  logic running;

  assign running  = (state == ST_RUN);
  assign startOk  = (state == ST_IDLE) && startPulse && streamEn &&
                    sampleValid && tReady && !pauseIn;
  assign beatOk   = running && sampleValid && tReady;
  assign frameEnd = beatOk && lastBeat;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (startOk) stateNxt = ST_RUN;
      ST_RUN: begin
        if (!(sampleValid && tReady))
          stateNxt = ST_HALT;
        else if (lastBeat && !(contLat && streamEn))
          stateNxt = ST_IDLE;
      end
      ST_HALT: if (!streamEn) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      contLat    <= 1'b0;
      freezeSeen <= 1'b0;
      errFlag    <= 1'b0;
    end else begin
      state <= stateNxt;
      if (startOk) contLat <= contMode;
      if (startOk || frameEnd)
        freezeSeen <= 1'b0;
      else if (running && freezeReq)
        freezeSeen <= 1'b1;
      if (startOk)
        errFlag <= 1'b0;
      else if (running && !(sampleValid && tReady))
        errFlag <= 1'b1;
    end
  end

  assign stb.load = startOk;
  assign stb.step = beatOk;
  assign tValid   = running && sampleValid;
  assign tLast    = tValid && lastBeat;
  assign tUser    = tLast && contLat && (freezeSeen || freezeReq);
endmodule

// File: rtl/frame_dpath.sv
module frame_dpath
  import pkt_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        stb,
  input  logic [LEN_W-1:0]               frameLen,
  input  logic                           hdrEn,
  input  logic                           contMode,
  input  logic [TIMING_WORDS*WORD_W-1:0] timingWord,
  input  logic [2*WORD_W-1:0]            timeStamp,
  input  logic [BSYNC_WORDS*WORD_W-1:0]  beamSync,
  input  logic [2:0]                     trigSrc,
  input  logic                           fmt16,
  input  logic                           avgEn,
  input  logic                           testMode,
  input  logic                           bayIdx,
  input  logic [3:0]                     chanIdx,
  input  logic [15:0]                    rateDiv,
  input  logic [WORD_W-1:0]              sampleData,
  output logic                           lastBeat,
  output logic [WORD_W-1:0]              tData,
  output logic [CNT_W-1:0]               frameCount
);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(HDR_N);

  logic [LEN_W-1:0]               idx;
  logic [LEN_W-1:0]               lenLat;
  logic [LEN_W-1:0]               effLen;
  logic                           hdrOn;
  logic [TIMING_WORDS*WORD_W-1:0] timingLat;
  logic [2*WORD_W-1:0]            tsLat;
  logic [BSYNC_WORDS*WORD_W-1:0]  bsLat;
  descWord_t                      descNow;
  descWord_t                      descLat;
  logic [WORD_W-1:0]              hdrWords [HDR_N];
  logic                           inHdr;
  logic [HDR_IDX_W-1:0]           hdrSel;

  assign effLen = (frameLen < MIN_LEN) ? MIN_LEN : frameLen;

  always_comb begin
    descNow.zero  = '0;
    descNow.trig  = trigSrc;
    descNow.fmt16 = fmt16;
    descNow.avg   = avgEn;
    descNow.test  = testMode;
    descNow.bay   = bayIdx;
    descNow.chan  = chanIdx;
    descNow.rate  = rateDiv;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx        <= '0;
      lenLat     <= MIN_LEN;
      hdrOn      <= 1'b0;
      timingLat  <= '0;
      tsLat      <= '0;
      bsLat      <= '0;
      descLat    <= '0;
      frameCount <= '0;
    end else if (stb.load) begin
      idx       <= '0;
      lenLat    <= effLen;
      hdrOn     <= hdrEn && !contMode;
      timingLat <= timingWord;
      tsLat     <= timeStamp;
      bsLat     <= beamSync;
      descLat   <= descNow;
    end else if (stb.step) begin
      if (lastBeat) begin
        idx        <= '0;
        frameCount <= frameCount + CNT_W'(1);
      end else begin
        idx <= idx + LEN_W'(1);
      end
    end
  end

  // header word assembly
  for (genvar g = 0; g < TIMING_WORDS; g++) begin : gTiming
    assign hdrWords[g] = timingLat[g*WORD_W +: WORD_W];
  end
  assign hdrWords[TIMING_WORDS]     = tsLat[WORD_W-1:0];
  assign hdrWords[TIMING_WORDS + 1] = tsLat[2*WORD_W-1:WORD_W];
  for (genvar b = 0; b < BSYNC_WORDS; b++) begin : gBsync
    assign hdrWords[TIMING_WORDS + 2 + b] = bsLat[(BSYNC_WORDS-1-b)*WORD_W +: WORD_W];
  end
  assign hdrWords[HDR_N-2] = {{(WORD_W-LEN_W){1'b0}}, lenLat};
  assign hdrWords[HDR_N-1] = descLat;

  assign lastBeat = (idx == lenLat - LEN_W'(1));
  assign inHdr    = hdrOn && (idx < MIN_LEN);
  assign hdrSel   = idx[HDR_IDX_W-1:0];
  assign tData    = inHdr ? hdrWords[hdrSel] : sampleData;
endmodule

// File: rtl/trig_frame_packer.sv
module trig_frame_packer
  import pkt_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           startPulse,
  input  logic [2:0]                     trigSrc,
  input  logic                           streamEn,
  input  logic                           contMode,
  input  logic                           hdrEn,
  input  logic                           pauseIn,
  input  logic                           freezeReq,
  input  logic [LEN_W-1:0]               frameLen,
  input  logic [WORD_W-1:0]              sampleData,
  input  logic                           sampleValid,
  input  logic [TIMING_WORDS*WORD_W-1:0] timingWord,
  input  logic [2*WORD_W-1:0]            timeStamp,
  input  logic [BSYNC_WORDS*WORD_W-1:0]  beamSync,
  input  logic                           fmt16,
  input  logic                           avgEn,
  input  logic                           testMode,
  input  logic                           bayIdx,
  input  logic [3:0]                     chanIdx,
  input  logic [15:0]                    rateDiv,
  output logic [WORD_W-1:0]              tData,
  output logic                           tValid,
  output logic                           tLast,
  output logic                           tUser,
  input  logic                           tReady,
  output logic                           errFlag,
  output logic [CNT_W-1:0]               frameCount
);
  strobe_t stb;
  logic    lastBeat;

  frame_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .streamEn   (streamEn),
    .contMode   (contMode),
    .pauseIn    (pauseIn),
    .freezeReq  (freezeReq),
    .sampleValid(sampleValid),
    .tReady     (tReady),
    .lastBeat   (lastBeat),
    .stb        (stb),
    .tValid     (tValid),
    .tLast      (tLast),
    .tUser      (tUser),
    .errFlag    (errFlag)
  );

  frame_dpath #(.LEN_W(LEN_W), .CNT_W(CNT_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .frameLen  (frameLen),
    .hdrEn     (hdrEn),
    .contMode  (contMode),
    .timingWord(timingWord),
    .timeStamp (timeStamp),
    .beamSync  (beamSync),
    .trigSrc   (trigSrc),
    .fmt16     (fmt16),
    .avgEn     (avgEn),
    .testMode  (testMode),
    .bayIdx    (bayIdx),
    .chanIdx   (chanIdx),
    .rateDiv   (rateDiv),
    .sampleData(sampleData),
    .lastBeat  (lastBeat),
    .tData     (tData),
    .frameCount(frameCount)
  );
endmodule

// File: rtl/trig_frame_packer_chk.sv
module trig_frame_packer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tValid,
  input logic             tLast,
  input logic             tUser,
  input logic             tReady,
  input logic             sampleValid,
  input logic             errFlag,
  input logic [CNT_W-1:0] frameCount
);
  // R10
  err_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !tValid);

  // R11
  count_on_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameCount != $past(frameCount)) |-> $past(tValid && tReady && tLast));

  // R9
  user_on_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    tUser |-> tLast);

  // R3
  frame_continues_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tValid && tReady && !tLast) |=> (tValid || !sampleValid));
endmodule

bind trig_frame_packer trig_frame_packer_chk #(.CNT_W(CNT_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .tValid     (tValid),
  .tLast      (tLast),
  .tUser      (tUser),
  .tReady     (tReady),
  .sampleValid(sampleValid),
  .errFlag    (errFlag),
  .frameCount (frameCount)
);

// File: tb/trig_frame_packer_test.sv
module trig_frame_packer_test;
  logic clk = 1'b0;
  logic rstN;
  logic startPulse, streamEn, contMode, hdrEn, pauseIn, freezeReq;
  logic [2:0]   trigSrc;
  logic [15:0]  frameLen;
  logic [31:0]  sampleData;
  logic         sampleValid;
  logic [191:0] timingWord;
  logic [63:0]  timeStamp;
  logic [127:0] beamSync;
  logic fmt16, avgEn, testMode, bayIdx;
  logic [3:0]   chanIdx;
  logic [15:0]  rateDiv;
  logic [31:0]  tData;
  logic tValid, tLast, tUser, tReady, errFlag;
  logic [15:0]  frameCount;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  // behavioural model state
  bit mAct, mHalt, mErr, mHdr, mCont, mFrz;
  int mIdx, mLen;
  logic [15:0] mCnt;
  logic [31:0] mHw [14];
  int beatCnt, userCnt;
  logic [31:0] w13Seen;

  always #5 clk = ~clk;

  trig_frame_packer uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .trigSrc(trigSrc),
    .streamEn(streamEn), .contMode(contMode), .hdrEn(hdrEn), .pauseIn(pauseIn),
    .freezeReq(freezeReq), .frameLen(frameLen), .sampleData(sampleData),
    .sampleValid(sampleValid), .timingWord(timingWord), .timeStamp(timeStamp),
    .beamSync(beamSync), .fmt16(fmt16), .avgEn(avgEn), .testMode(testMode),
    .bayIdx(bayIdx), .chanIdx(chanIdx), .rateDiv(rateDiv), .tData(tData),
    .tValid(tValid), .tLast(tLast), .tUser(tUser), .tReady(tReady),
    .errFlag(errFlag), .frameCount(frameCount)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int effLenOf(input logic [15:0] len);
    return (len < 16'd14) ? 14 : int'(len);
  endfunction

  function automatic logic [31:0] hdrExp(input int k);
    if (k < 6) return timingWord[k*32 +: 32];
    if (k == 6) return timeStamp[31:0];
    if (k == 7) return timeStamp[63:32];
    if (k < 12) return beamSync[(11-k)*32 +: 32];
    if (k == 12) return 32'(effLenOf(frameLen));
    return {5'b0, trigSrc, fmt16, avgEn, testMode, bayIdx, chanIdx, rateDiv};
  endfunction

  // one clock cycle: compare with the model, advance the model, cross the edge
  task automatic step();
    logic expV, expL, expU;
    logic [31:0] expD;
    string dl;
    #2;
    expV = mAct && sampleValid;
    expL = expV && (mIdx == mLen - 1);
    expU = expL && mCont && (mFrz || freezeReq);
    if (mHdr && mIdx < 14) begin
      expD = mHw[mIdx];
      dl = (mIdx == 13) ? "R5" : "R4/R6";
    end else begin
      expD = sampleData;
      dl = mCont ? "R8" : "R7";
    end
    chk(tValid === expV, "R2", "tValid", 32'(tValid), 32'(expV));
    if (expV && tValid) chk(tData === expD, dl, "tData", tData, expD);
    chk(tLast === expL, "R3", "tLast", 32'(tLast), 32'(expL));
    chk(tUser === expU, "R9", "tUser", 32'(tUser), 32'(expU));
    chk(errFlag === mErr, "R10", "errFlag", 32'(errFlag), 32'(mErr));
    chk(frameCount === mCnt, "R11", "frameCount", 32'(frameCount), 32'(mCnt));
    if (tValid && tReady) begin
      if (beatCnt == 13) w13Seen = tData;
      beatCnt++;
    end
    if (tUser) userCnt++;
    if (mAct) begin
      if (sampleValid && tReady) begin
        if (mIdx == mLen - 1) begin
          mCnt++;
          mFrz = 0;
          if (mCont && streamEn) mIdx = 0;
          else mAct = 0;
        end else begin
          mIdx++;
          if (freezeReq) mFrz = 1;
        end
      end else begin
        mAct = 0; mHalt = 1; mErr = 1;
      end
    end else if (mHalt) begin
      if (!streamEn) mHalt = 0;
    end else if (startPulse && streamEn && sampleValid && tReady && !pauseIn) begin
      mAct = 1; mIdx = 0; mLen = effLenOf(frameLen);
      mHdr = hdrEn && !contMode; mCont = contMode; mErr = 0; mFrz = 0;
      for (int k = 0; k < 14; k++) mHw[k] = hdrExp(k);
    end
    @(posedge clk);
    #1;
    sampleData = $urandom;
  endtask

  task automatic runSteps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic trigger();
    startPulse = 1'b1;
    beatCnt = 0;
    step();
    startPulse = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; startPulse = 0; trigSrc = 0; streamEn = 1; contMode = 0;
    hdrEn = 0; pauseIn = 0; freezeReq = 0; frameLen = 16'd16; sampleData = 0;
    sampleValid = 1; tReady = 1; timingWord = {6{$urandom}}; timeStamp = {$urandom, $urandom};
    beamSync = {$urandom, $urandom, $urandom, $urandom}; fmt16 = 0; avgEn = 0;
    testMode = 0; bayIdx = 0; chanIdx = 0; rateDiv = 0;
    mAct = 0; mHalt = 0; mErr = 0; mHdr = 0; mCont = 0; mFrz = 0; mIdx = 0; mLen = 14;
    mCnt = 0; beatCnt = 0; userCnt = 0; w13Seen = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(tValid === 1'b0, "R1", "tValid in reset", 32'(tValid), 0);
    rstN = 1'b1;
    #1;
    chk(tValid === 1'b0 && errFlag === 1'b0, "R1", "tValid/errFlag after reset",
        32'({tValid, errFlag}), 0);
    chk(frameCount === 16'd0, "R1", "frameCount after reset", 32'(frameCount), 0);
    runSteps(2);

    // triggered frame with header; header inputs change after the start
    hdrEn = 1; frameLen = 16'd20; trigSrc = 3'b101; fmt16 = 1; avgEn = 0;
    testMode = 1; bayIdx = 1; chanIdx = 4'd9; rateDiv = 16'h1234;
    trigger();
    timingWord = ~timingWord; timeStamp = ~timeStamp; beamSync = ~beamSync;
    trigSrc = 3'b010; rateDiv = 16'hFFFF;
    runSteps(22);
    chk(beatCnt == 20, "R3", "beats with header", 32'(beatCnt), 20);
    chk(w13Seen === 32'h05B9_1234, "R5", "descriptor word", w13Seen, 32'h05B9_1234);
    chk(frameCount === 16'd1, "R11", "count after frame", 32'(frameCount), 1);

    // short length clamps to 14; mid-frame start pulse ignored
    hdrEn = 0; frameLen = 16'd5;
    trigger();
    runSteps(4);
    startPulse = 1; step(); startPulse = 0;
    runSteps(9);
    chk(beatCnt == 14, "R3", "clamped beats", 32'(beatCnt), 14);
    chk(tValid === 1'b0, "R12", "no frame from mid-frame pulse", 32'(tValid), 0);
    runSteps(3);

    // valid drop aborts; halted until enable drops; restart clears error
    frameLen = 16'd16;
    trigger();
    runSteps(4);
    sampleValid = 0; step(); sampleValid = 1;
    chk(errFlag === 1'b1 && tValid === 1'b0, "R10", "abort on valid drop",
        32'({errFlag, tValid}), 32'h2);
    trigger();
    chk(tValid === 1'b0 && errFlag === 1'b1, "R10", "start blocked while halted",
        32'({errFlag, tValid}), 32'h2);
    streamEn = 0; step(); streamEn = 1;
    trigger();
    chk(errFlag === 1'b0, "R10", "error cleared on restart", 32'(errFlag), 0);
    runSteps(5);
    tReady = 0; step(); tReady = 1;
    chk(errFlag === 1'b1, "R10", "abort on ready drop", 32'(errFlag), 1);
    chk(frameCount === 16'd2, "R11", "aborted frames not counted", 32'(frameCount), 2);
    streamEn = 0; step(); streamEn = 1;

    // pause blocks a start
    pauseIn = 1; startPulse = 1; step(); startPulse = 0; pauseIn = 0;
    chk(tValid === 1'b0, "R2", "start under pause", 32'(tValid), 0);

    // continuous: three back-to-back frames, freeze in the second
    contMode = 1; hdrEn = 1; frameLen = 16'd14; userCnt = 0;
    trigger();
    runSteps(19);
    freezeReq = 1; step(); freezeReq = 0;
    runSteps(14);
    streamEn = 0;
    runSteps(20);
    streamEn = 1; contMode = 0;
    chk(frameCount === 16'd5, "R8", "continuous frame count", 32'(frameCount), 5);
    chk(tValid === 1'b0, "R8", "stopped after disable", 32'(tValid), 0);
    chk(userCnt == 1, "R9", "freeze marks", 32'(userCnt), 1);

    // seeded random traffic
    for (int i = 0; i < 3000; i++) begin
      startPulse  = ($urandom_range(0, 9) == 0);
      trigSrc     = 3'($urandom);
      sampleValid = ($urandom_range(0, 99) < 98);
      tReady      = ($urandom_range(0, 99) < 98);
      pauseIn     = ($urandom_range(0, 9) == 0);
      freezeReq   = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 19) == 0) streamEn = ~streamEn;
      if ($urandom_range(0, 29) == 0) contMode = ~contMode;
      hdrEn       = 1'($urandom);
      frameLen    = 16'($urandom_range(8, 40));
      fmt16 = 1'($urandom); avgEn = 1'($urandom); testMode = 1'($urandom);
      bayIdx = 1'($urandom); chanIdx = 4'($urandom); rateDiv = 16'($urandom);
      if ($urandom_range(0, 3) == 0) timingWord[($urandom_range(0, 5))*32 +: 32] = $urandom;
      timeStamp = timeStamp + 64'd1;
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end
endmodule